// File: doc/BRIEF.md
# Transmit Audio Sample FIFO Channel

This block is a single outbound channel of a serial audio link controller. A host writes 32-bit words into a small FIFO. A frame builder walks the slots of each outgoing frame. For every slot it asks the channel for data, and the channel answers in the same cycle with a 20-bit slot value.

A control register decides several things: whether the full FIFO depth is used, whether each word carries one sample or two 16-bit samples, the sample width, and which of slots 1 to 12 the channel serves. A status vector reports the FIFO level and a sticky underrun flag. A masked interrupt vector signals a refill request, transmit completion and underrun.

Disabling transmit only freezes the channel and keeps its contents. Dropping the interface enable flushes the FIFO.

Top module: `tx_audio_chan`

## Requirements
- R1: The control register holds FIFO enable at bit 16, compact packing at bit 15, sample size at bits 14:13 (00=16, 01=18, 10=20, 11=12 bits), slot enables for slots 1..12 at bits 12:1 (bit n serves slot n), and transmit enable at bit 0.
- R2: With FIFO enable set, the FIFO holds 8 words. The full flag asserts once 8 words are stored, and a write while full is dropped.
- R3: With FIFO enable clear, the channel holds only one word. Full asserts after one write, and a second write is dropped.
- R4: In compact mode each word yields two samples: bits 15:0 first, then bits 31:16. The word leaves the FIFO only after its upper half is sent.
- R5: Samples are left-aligned in the 20-bit slot value with zero fill below: 16-bit at 19:4, 18-bit at 19:2, 20-bit at 19:0, 12-bit at 19:8.
- R6: A slot request consumes exactly one sample, in request order, only when its slot is enabled, transmit is enabled and the interface is enabled. Any other request returns zero and consumes nothing.
- R7: A request that would consume while the FIFO is empty returns zero and sets a sticky underrun flag. Pulsing the clear input resets the flag, and the clear wins over a new underrun in the same cycle.
- R8: With transmit enable clear, slot requests leave the FIFO contents and the underrun flag untouched. Data written before resumes in order once transmit is enabled again.
- R9: While the interface enable is low, the FIFO is emptied, the compact half pointer is reset and host writes are ignored.
- R10: The status vector carries underrun at bit 9, busy (transmit enabled and FIFO not empty) at bit 7, full at bit 5, half-empty at bit 3 and empty at bit 1. All other bits read 0. Half-empty means at most 4 words when FIFO enable is set, and empty otherwise.
- R11: The interrupt vector is underrun AND enable bit 5 at bit 5, half-empty AND transmit enable AND enable bit 2 at bit 2, and empty AND transmit enable AND enable bit 0 at bit 0. The irq output is the OR of the interrupt vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iface_en | input | 1 | Interface enable; low flushes the FIFO |
| data_wr | input | 1 | Host FIFO write strobe |
| data_in | input | 32 | Host FIFO write word |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_in | input | 17 | Control register value |
| inten_wr | input | 1 | Interrupt enable write strobe |
| inten_in | input | 7 | Interrupt enable value |
| udr_clr | input | 1 | Underrun clear pulse |
| slot_req | input | 1 | Frame builder requests a sample |
| slot_idx | input | 4 | Slot number of the request (1..12) |
| slot_data | output | 20 | Slot value answered in the request cycle |
| status | output | 12 | FIFO status vector |
| int_stat | output | 7 | Masked interrupt status |
| irq | output | 1 | Channel interrupt |

## Verification
Directed sequences first fill the FIFO past its depth, with FIFO enable both set and clear, to separate the 8-word mode from the one-word mode. A single word is then split in compact mode to show the half order. One word is sent at every sample size to tell the alignments apart. A six-slot request pattern with a disabled slot in the middle shows that only enabled slots consume. Other sequences drain an empty FIFO to provoke underrun, pause transmit to show the contents are kept, and drop the interface enable to show the flush. A seeded random mix of writes, requests to any slot number, control rewrites, clears and flushes then compares every answer and status word against a queue model, which exposes ordering and counting slips that the directed cases miss.

// File: rtl/tx_audio_chan.sv
module tx_audio_chan #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        iface_en,
  input  logic        data_wr,
  input  logic [31:0] data_in,
  input  logic        ctrl_wr,
  input  logic [16:0] ctrl_in,
  input  logic        inten_wr,
  input  logic [6:0]  inten_in,
  input  logic        udr_clr,
  input  logic        slot_req,
  input  logic [3:0]  slot_idx,
  output logic [19:0] slot_data,
  output logic [11:0] status,
  output logic [6:0]  int_stat,
  output logic        irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_N = CW'(DEPTH / 2);

  logic [16:0]   ctrl;
  logic [6:0]    inten;
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          half, udr;

  wire       txen    = ctrl[0];
  wire       compact = ctrl[15];
  wire       fen     = ctrl[16];
  wire [1:0] ssz     = ctrl[14:13];

  wire [CW-1:0] cap   = fen ? FULL_N : CW'(1);
  wire          empty = (count == '0);
  wire          full  = (count >= cap);
  wire          hempty = fen ? (count <= HALF_N) : empty;

  wire slot_on = (slot_idx >= 4'd1) && (slot_idx <= 4'd12) && ctrl[slot_idx];
  wire want    = slot_req && slot_on && txen && iface_en;
  wire take    = want && !empty;
  wire starve  = want && empty;
  wire pop     = take && (!compact || half);
  wire push    = data_wr && iface_en && !full;

  logic [31:0] word, src;
  logic [19:0] fmt;
  assign word = mem[rd_ptr];
  assign src  = compact ? {16'h0, (half ? word[31:16] : word[15:0])} : word;

  always_comb begin
    case (ssz)
      2'd0:    fmt = {src[15:0], 4'h0};
      2'd1:    fmt = {src[17:0], 2'h0};
      2'd2:    fmt = src[19:0];
      default: fmt = {src[11:0], 8'h0};
    endcase
  end

  assign slot_data = take ? fmt : 20'h0;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      inten  <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      half   <= 1'b0;
      udr    <= 1'b0;
    end else begin
      if (ctrl_wr)  ctrl  <= ctrl_in;
      if (inten_wr) inten <= inten_in;
      if (udr_clr)     udr <= 1'b0;
      else if (starve) udr <= 1'b1;
      if (!iface_en) begin
        rd_ptr <= '0;
        wr_ptr <= '0;
        count  <= '0;
        half   <= 1'b0;
      end else begin
        if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        if (take) half <= compact && !half;
        count <= count + CW'(push) - CW'(pop);
      end
    end
  end

  assign status = {2'b00, udr, 1'b0, txen && !empty, 1'b0, full,
                   1'b0, hempty, 1'b0, empty, 1'b0};

  assign int_stat = {1'b0, udr && inten[5], 2'b00,
                     hempty && txen && inten[2], 1'b0,
                     empty && txen && inten[0]};

  assign irq = |int_stat;
endmodule

module tx_audio_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        iface_en,
  input logic        data_wr,
  input logic        ctrl_wr,
  input logic        udr_clr,
  input logic        slot_req,
  input logic [3:0]  slot_idx,
  input logic [16:0] ctrl,
  input logic [19:0] slot_data,
  input logic [11:0] status
);
  wire on = (slot_idx >= 4'd1) && (slot_idx <= 4'd12) && ctrl[slot_idx];
  wire dry = slot_req && on && ctrl[0] && iface_en && status[1];

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    !iface_en |=> status[1]); // R9
  AST_UDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dry |-> slot_data == 20'h0); // R7
  AST_UDR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (dry && !udr_clr) |=> status[9]); // R7
  AST_UDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[9] && !udr_clr) |=> status[9]); // R7
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (iface_en && !ctrl[0] && !data_wr && !ctrl_wr) |=> $stable(status[5:1])); // R8
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && iface_en && !slot_req && !ctrl_wr) |=> status[5]); // R2
  AST_OFF_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !on) |-> slot_data == 20'h0); // R6
endmodule

bind tx_audio_chan tx_audio_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .iface_en(iface_en), .data_wr(data_wr),
  .ctrl_wr(ctrl_wr), .udr_clr(udr_clr), .slot_req(slot_req),
  .slot_idx(slot_idx), .ctrl(ctrl), .slot_data(slot_data), .status(status)
);

// File: tb/sim_tx_audio_chan.sv
module sim_tx_audio_chan;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iface_en, data_wr, ctrl_wr, inten_wr, udr_clr, slot_req;
  logic [31:0] data_in;
  logic [16:0] ctrl_in;
  logic [6:0]  inten_in;
  logic [3:0]  slot_idx;
  logic [19:0] slot_data;
  logic [11:0] status;
  logic [6:0]  int_stat;
  logic        irq;

  always #5 clk = ~clk;

  tx_audio_chan #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .iface_en(iface_en), .data_wr(data_wr),
    .data_in(data_in), .ctrl_wr(ctrl_wr), .ctrl_in(ctrl_in),
    .inten_wr(inten_wr), .inten_in(inten_in), .udr_clr(udr_clr),
    .slot_req(slot_req), .slot_idx(slot_idx), .slot_data(slot_data),
    .status(status), .int_stat(int_stat), .irq(irq)
  );

  int nvec = 0, nbad = 0;
  logic [31:0] mq[$];
  bit          mhalf = 0, mudr = 0;
  logic [16:0] mctrl = '0;
  logic [6:0]  minten = '0;
  logic [19:0] last_data;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [19:0] fmt(logic [31:0] w, bit h, bit cmp, logic [1:0] sz);
    logic [31:0] s;
    s = cmp ? {16'h0, (h ? w[31:16] : w[15:0])} : w;
    case (sz)
      2'd0:    return {s[15:0], 4'h0};
      2'd1:    return {s[17:0], 2'h0};
      2'd2:    return s[19:0];
      default: return {s[11:0], 8'h0};
    endcase
  endfunction

  function automatic logic [11:0] exp_status();
    logic [11:0] s;
    int cap;
    cap = mctrl[16] ? DEPTH : 1;
    s = '0;
    s[9] = mudr;
    s[7] = mctrl[0] && (mq.size() > 0);
    s[5] = mq.size() >= cap;
    s[3] = mctrl[16] ? (mq.size() <= DEPTH/2) : (mq.size() == 0);
    s[1] = mq.size() == 0;
    return s;
  endfunction

  function automatic logic [6:0] exp_int();
    logic [11:0] s;
    logic [6:0] i;
    s = exp_status();
    i = '0;
    i[5] = s[9] && minten[5];
    i[2] = s[3] && mctrl[0] && minten[2];
    i[0] = s[1] && mctrl[0] && minten[0];
    return i;
  endfunction

  task automatic idle();
    data_wr = 0; ctrl_wr = 0; inten_wr = 0; udr_clr = 0; slot_req = 0;
  endtask

  task automatic tick();
    int cap;
    bit full, on, want, empty;
    logic [19:0] ed;
    cap   = mctrl[16] ? DEPTH : 1;
    full  = mq.size() >= cap;
    empty = mq.size() == 0;
    on    = slot_idx >= 1 && slot_idx <= 12 && mctrl[slot_idx];
    want  = slot_req && on && mctrl[0] && iface_en;
    ed    = (want && !empty) ? fmt(mq[0], mhalf, mctrl[15], mctrl[14:13]) : 20'h0;
    #1;
    last_data = slot_data;
    if (slot_req) chk("R6 slot data", slot_data, ed);
    @(posedge clk);
    if (udr_clr) mudr = 0;
    else if (want && empty) mudr = 1;
    if (!iface_en) begin
      mq.delete();
      mhalf = 0;
    end else begin
      if (want && !empty) begin
        if (mctrl[15] && !mhalf) mhalf = 1;
        else begin void'(mq.pop_front()); mhalf = 0; end
      end
      if (data_wr && !full) mq.push_back(data_in);
    end
    if (ctrl_wr)  mctrl  = ctrl_in;
    if (inten_wr) minten = inten_in;
    @(negedge clk);
    chk("R10 status", status, exp_status());
    chk("R11 interrupts", {irq, int_stat}, {|exp_int(), exp_int()});
    idle();
  endtask

  task automatic wr(logic [31:0] w);
    data_wr = 1; data_in = w; tick();
  endtask
  task automatic setctrl(logic [16:0] v);
    ctrl_wr = 1; ctrl_in = v; tick();
  endtask
  task automatic req(logic [3:0] s);
    slot_req = 1; slot_idx = s; tick();
  endtask
  task automatic clr();
    udr_clr = 1; tick();
  endtask

  initial begin
    #2_000_000;
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    iface_en = 1; data_in = '0; ctrl_in = '0; inten_in = '0; slot_idx = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset status", status, 32'h00A);
    chk("R11 reset interrupts", int_stat, 32'h0);

    inten_wr = 1; inten_in = 7'h25; tick();

    // R2: 8-word depth, ninth write dropped
    setctrl(17'h10000);
    for (int i = 0; i < 8; i++) wr(32'(i + 1));
    chk("R2 full after 8 writes", status[5], 1);
    wr(32'h99);
    setctrl(17'h10019);
    for (int i = 0; i < 8; i++) begin
      req((i % 2) ? 4'd4 : 4'd3);
      chk("R2 fifo order", last_data, {16'(i + 1), 4'h0});
    end
    req(4'd3);
    chk("R2 ninth write dropped", last_data, 0);
    chk("R7 underrun flag", status[9], 1);
    chk("R7 underrun interrupt", int_stat[5], 1);
    clr();
    chk("R7 underrun cleared", status[9], 0);

    // R3: one-word holding when FIFO enable clear
    setctrl(17'h00019);
    wr(32'h111);
    chk("R3 full after one write", status[5], 1);
    wr(32'h222);
    req(4'd3);
    chk("R3 first word", last_data, 20'h01110);
    req(4'd4);
    chk("R3 second write dropped", last_data, 0);
    clr();

    // R4: compact low half then high half
    setctrl(17'h18019);
    wr(32'hBBBB_AAAA);
    req(4'd3);
    chk("R4 low half first", last_data, 20'hAAAA0);
    chk("R4 word kept after low half", status[1], 0);
    req(4'd4);
    chk("R4 high half second", last_data, 20'hBBBB0);
    chk("R4 word gone after high half", status[1], 1);

    // R5: alignment by size
    for (int z = 0; z < 4; z++) begin
      setctrl(17'h10009 | (17'(z) << 13));
      wr(32'h1234_5678);
      req(4'd3);
      case (z)
        0: chk("R5 16-bit", last_data, 20'h56780);
        1: chk("R5 18-bit", last_data, 20'h159E0);
        2: chk("R5 20-bit", last_data, 20'h45678);
        default: chk("R5 12-bit", last_data, 20'h67800);
      endcase
    end

    // R8: transmit disabled keeps contents
    setctrl(17'h10008);
    wr(32'h0A1);
    wr(32'h0A2);
    req(4'd3);
    req(4'd3);
    chk("R8 no data while disabled", last_data, 0);
    chk("R8 contents kept", status[1], 0);
    chk("R8 no underrun while disabled", status[9], 0);
    setctrl(17'h10009);
    req(4'd3);
    chk("R8 resumes in order", last_data, 20'h00A10);

    // R9: flush and writes ignored while interface disabled
    iface_en = 0; tick();
    chk("R9 flushed", status[1], 1);
    data_wr = 1; data_in = 32'h55; tick();
    chk("R9 write ignored", status[1], 1);
    iface_en = 1;

    // R1 / R6: six-slot mask, disabled slot 5 in the middle
    setctrl(17'h103D9);
    for (int k = 0; k < 6; k++) wr(32'hA0 + 32'(k));
    begin
      logic [3:0] order [7];
      int n;
      order = '{4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9};
      n = 0;
      for (int k = 0; k < 7; k++) begin
        req(order[k]);
        if (order[k] == 4'd5) chk("R6 disabled slot zero", last_data, 0);
        else begin
          chk("R1 slot mask order", last_data, {16'(32'hA0 + 32'(n)), 4'h0});
          n++;
        end
      end
    end

    // R11: interrupt sources
    chk("R11 complete and request", int_stat, 32'h05);
    inten_wr = 1; inten_in = 7'h00; tick();
    chk("R11 masked", {irq, int_stat}, 0);
    inten_wr = 1; inten_in = 7'h25; tick();

    // random mix
    for (int t = 0; t < 4000; t++) begin
      int r;
      r = $urandom % 100;
      iface_en = ($urandom % 64) != 0;
      if (r < 40) begin data_wr = 1; data_in = $urandom; end
      if (r >= 30 && r < 80) begin slot_req = 1; slot_idx = 4'($urandom); end
      if (r >= 95) begin
        ctrl_wr = 1;
        ctrl_in = 17'($urandom);
        if ($urandom % 4 != 0) ctrl_in[0] = 1;
        if ($urandom % 4 != 0) ctrl_in[16] = 1;
      end
      if (r >= 90 && r < 93) udr_clr = 1;
      if (r == 93) begin inten_wr = 1; inten_in = 7'($urandom); end
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule